// File: doc/BRIEF.md
# Single-Cycle Eight-Register Microcore

This block is a very small processor. It takes one 16-bit instruction word in each clock cycle and executes it fully in that same cycle. The word comes from an instruction port, indexed by the program counter. Results go to eight 8-bit general registers. Register 0 is wired to the value zero. The only way to memory is a separate data write port, driven by store instructions. Branching is a single conditional jump that tests a register for non-zero. That is enough to write counted loops.

Decode is a lookup. The 4-bit opcode indexes a table of control words, and each control word is a small set of strobes. The strobes steer the register write, the ALU function, the second-operand select, the store and the jump. The all-zero word is a move from register 0 to register 0, which has no effect, so a cleared instruction memory runs as a run of NOPs. Add and subtract use one spare bit of the word to choose between a register operand and an 8-bit immediate.

Top module: `mini_cpu`

## Requirements
- R1: Move-immediate (opcode 1) writes bits 7:0 of the word into the register selected by bits 11:9.
- R2: Register move (opcode 0) copies register [8:6] into register [11:9]. The word 0x0000 changes no register, no memory and no control flow.
- R3: Add (opcode 2) and subtract (opcode 3) in register form, with bit 8 clear, compute Rd = Rd ± register[8:6] modulo 256. In this form the source field reaches registers 0 to 3.
- R4: With bit 8 set, add and subtract take bits 7:0 of the word as the second operand, modulo 256.
- R5: Register 0 always reads as 0, including straight after an instruction that writes to it.
- R6: Store (opcode 4) raises the write enable for exactly that cycle. The address is register [11:9] and the data is register [8:6]. No other opcode raises the write enable.
- R7: Jump-not-zero (opcode 5) loads the program counter with bits 7:0 when register [11:9] is non-zero. Otherwise it falls through to the next word.
- R8: The 8-bit program counter reads 0 in the cycle after reset. It then advances by one per instruction and wraps from 255 to 0.
- R9: Opcodes 6 to 15 change no register, no memory and no control flow.
- R10: A Fibonacci loop built from these instructions stores 1, 2, 3, 5, 8 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears the PC and registers |
| imemAddr | output | PC_W | Program counter, used as the instruction read address |
| imemData | input | 16 | Instruction word at imemAddr, read combinationally |
| memAddr | output | DATA_W | Data memory write address |
| memWData | output | DATA_W | Data memory write data |
| memWe | output | 1 | Data memory write enable |

## Verification
The bench builds the core with its default widths: 8-bit data and an 8-bit program counter. At these widths every arithmetic result is checked against a modulo-256 value that the bench computes itself. The bench sweeps operand pairs over a grid of roughly two thousand combinations across the full byte range. For each pair it loads a generated program that exercises every opcode class, the zero register, the NOP word, an unused opcode and an untaken jump. A separate program walks the program counter through its wrap from 255 to 0. Finally, a fixed Fibonacci loop checks the store sequence.

// File: rtl/mini_cpu_pkg.sv
package mini_cpu_pkg;
  localparam int INSTR_W = 16;
  localparam int NUM_REGS = 8;
  localparam int RIDX_W = $clog2(NUM_REGS);
  localparam int IMM_W = 8;

  localparam logic [3:0] OP_MOVR = 4'd0;
  localparam logic [3:0] OP_MOVI = 4'd1;
  localparam logic [3:0] OP_ADD  = 4'd2;
  localparam logic [3:0] OP_SUB  = 4'd3;
  localparam logic [3:0] OP_STR  = 4'd4;
  localparam logic [3:0] OP_JNZ  = 4'd5;

  typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_SUB} aluOp_e;

  typedef struct packed {
    logic   regWrite;
    logic   forceImm;   // second operand always the immediate
    logic   flagImm;    // bit 8 chooses immediate
    aluOp_e aluOp;
    logic   memWrite;
    logic   branch;
  } ctrl_t;
endpackage

// File: rtl/mini_cpu_control.sv
module mini_cpu_control
  import mini_cpu_pkg::*;
(
  input  logic [3:0] opcode,
  output ctrl_t      ctrl
);
  function automatic ctrl_t romEntry(input int op);
    ctrl_t e;
    e = '{regWrite: 1'b0, forceImm: 1'b0, flagImm: 1'b0,
          aluOp: ALU_PASS, memWrite: 1'b0, branch: 1'b0};
    case (op)
      int'(OP_MOVR): e.regWrite = 1'b1;
      int'(OP_MOVI): begin e.regWrite = 1'b1; e.forceImm = 1'b1; end
      int'(OP_ADD):  begin e.regWrite = 1'b1; e.flagImm = 1'b1; e.aluOp = ALU_ADD; end
      int'(OP_SUB):  begin e.regWrite = 1'b1; e.flagImm = 1'b1; e.aluOp = ALU_SUB; end
      int'(OP_STR):  e.memWrite = 1'b1;
      int'(OP_JNZ):  e.branch = 1'b1;
      default: ;
    endcase
    return e;
  endfunction

  ctrl_t ctrlRom [16];

  for (genvar i = 0; i < 16; i++) begin : g_rom
    assign ctrlRom[i] = romEntry(i);
  end

  assign ctrl = ctrlRom[opcode];
endmodule

// File: rtl/mini_cpu_datapath.sv
module mini_cpu_datapath
  import mini_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrl_t              ctrl,
  input  logic [INSTR_W-1:0] instr,
  output logic [PC_W-1:0]    pc,
  output logic [DATA_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWData,
  output logic               memWe,
  output logic               jumpTaken
);
  localparam int BANK_W = NUM_REGS * DATA_W;

  logic [RIDX_W-1:0] rdIdx, rsIdx;
  logic [IMM_W-1:0]  imm;
  logic              immBit;
  logic [BANK_W-1:0] regBank;
  logic [DATA_W-1:0] rdVal, rsVal, opB, aluOut;

  assign rdIdx  = instr[11:9];
  assign rsIdx  = instr[8:6];
  assign immBit = instr[8];
  assign imm    = instr[IMM_W-1:0];

  assign rdVal = (rdIdx == '0) ? '0 : regBank[rdIdx*DATA_W +: DATA_W];
  assign rsVal = (rsIdx == '0) ? '0 : regBank[rsIdx*DATA_W +: DATA_W];

  assign opB = (ctrl.forceImm || (ctrl.flagImm && immBit)) ? DATA_W'(imm) : rsVal;

  always_comb begin
    case (ctrl.aluOp)
      ALU_ADD: aluOut = rdVal + opB;
      ALU_SUB: aluOut = rdVal - opB;
      default: aluOut = opB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regBank <= '0;
    end else if (ctrl.regWrite && rdIdx != '0) begin
      regBank[rdIdx*DATA_W +: DATA_W] <= aluOut;
    end
  end

  assign jumpTaken = !rst && ctrl.branch && (rdVal != '0);

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else if (jumpTaken) pc <= PC_W'(imm);
    else pc <= pc + 1'b1;
  end

  assign memWe    = !rst && ctrl.memWrite;
  assign memAddr  = rdVal;
  assign memWData = rsVal;
endmodule

// File: rtl/mini_cpu.sv
module mini_cpu
  import mini_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  output logic [DATA_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWData,
  output logic               memWe
);
  ctrl_t ctrl;
  logic  jumpTaken;

  mini_cpu_control i_control (
    .opcode(imemData[15:12]),
    .ctrl  (ctrl)
  );

  mini_cpu_datapath #(.DATA_W(DATA_W), .PC_W(PC_W)) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .instr    (imemData),
    .pc       (imemAddr),
    .memAddr  (memAddr),
    .memWData (memWData),
    .memWe    (memWe),
    .jumpTaken(jumpTaken)
  );
endmodule

// File: rtl/mini_cpu_checker.sv
module mini_cpu_checker #(
  parameter int DATA_W = 8,
  parameter int PC_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [PC_W-1:0]   imemAddr,
  input logic [15:0]       imemData,
  input logic [DATA_W-1:0] memWData,
  input logic              memWe,
  input logic              jumpTaken
);
  AST_PC_RESET: assert property (@(posedge clk) rst |=> imemAddr == '0); // R8
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    !jumpTaken |=> imemAddr == $past(imemAddr) + 1'b1); // R8
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    jumpTaken |=> imemAddr == PC_W'($past(imemData[7:0]))); // R7
  AST_JUMP_OPCODE: assert property (@(posedge clk) disable iff (rst)
    jumpTaken |-> imemData[15:12] == 4'd5); // R7
  AST_STORE_OPCODE: assert property (@(posedge clk) disable iff (rst)
    memWe |-> imemData[15:12] == 4'd4); // R6
  AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (memWe && imemData[8:6] == 3'd0) |-> memWData == '0); // R5
endmodule

bind mini_cpu mini_cpu_checker #(.DATA_W(DATA_W), .PC_W(PC_W)) i_checker (
  .clk      (clk),
  .rst      (rst),
  .imemAddr (imemAddr),
  .imemData (imemData),
  .memWData (memWData),
  .memWe    (memWe),
  .jumpTaken(jumpTaken)
);

// File: tb/test_mini_cpu.sv
module test_mini_cpu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] imemAddr;
  logic [15:0] imemData;
  logic [7:0] memAddr, memWData;
  logic       memWe;

  logic [15:0] imem [256];
  logic [7:0]  logAddr [64];
  logic [7:0]  logData [64];
  int logCnt = 0;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  assign imemData = imem[imemAddr];

  mini_cpu i_mini_cpu (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .memAddr(memAddr), .memWData(memWData), .memWe(memWe)
  );

  always @(negedge clk) begin
    cycles++;
    if (!rst && memWe && logCnt < 64) begin
      logAddr[logCnt] = memAddr;
      logData[logCnt] = memWData;
      logCnt++;
    end
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles, expected < 150000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [15:0] enc(input int op, input int rd, input int rs, input int im);
    return 16'((op << 12) | (rd << 9) | (rs << 6) | im);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h, expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) imem[i] = 16'h0000;
  endtask

  task automatic startRun();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    logCnt = 0;
    rst = 1'b0;
  endtask

  initial begin
    int a, b;
    // Reset state
    clearMem();
    startRun();
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset pc", imemAddr, 0);
    check("R6 reset we", memWe, 0);

    // R10: Fibonacci loop
    clearMem();
    imem[0]  = enc(1, 1, 0, 0);
    imem[1]  = enc(1, 2, 0, 1);
    imem[2]  = enc(1, 4, 0, 5);
    imem[3]  = enc(0, 3, 1, 0);
    imem[4]  = enc(2, 3, 2, 0);
    imem[5]  = enc(0, 1, 2, 0);
    imem[6]  = enc(0, 2, 3, 0);
    imem[7]  = enc(4, 0, 3, 0);
    imem[8]  = enc(3, 4, 0, 9'h101);
    imem[9]  = enc(5, 4, 0, 3);
    imem[10] = enc(5, 2, 0, 10);
    startRun();
    repeat (60) @(negedge clk);
    check("R10 store count", logCnt, 5);
    begin
      int fib [5] = '{1, 2, 3, 5, 8};
      for (int i = 0; i < 5; i++) begin
        check("R10 fib data", logData[i], fib[i]);
        check("R10 fib addr", logAddr[i], 0);
      end
    end
    check("R7 jump to self", imemAddr, 10);

    // R8: program counter wrap
    clearMem();
    imem[0]   = enc(1, 1, 0, 1);
    imem[1]   = enc(5, 1, 0, 8'hFE);
    imem[254] = enc(4, 0, 1, 0);
    startRun();
    begin
      int pcSeq [6] = '{0, 1, 254, 255, 0, 1};
      for (int i = 0; i < 6; i++) begin
        check("R8 pc sequence", imemAddr, pcSeq[i]);
        @(negedge clk);
      end
    end
    check("R6 wrap store data", logData[0], 1);

    // Operand sweep over a generated program
    for (int ai = 0; ai < 52; ai++) begin
      for (int bi = 0; bi < 37; bi++) begin
        a = ai * 5;
        b = bi * 7;
        clearMem();
        imem[0]  = enc(1, 1, 0, a);
        imem[1]  = enc(1, 2, 0, b);
        imem[2]  = enc(1, 7, 0, a);
        imem[3]  = enc(0, 3, 1, 0);
        imem[4]  = enc(2, 3, 2, 0);
        imem[5]  = enc(4, 7, 3, 0);
        imem[6]  = enc(0, 3, 1, 0);
        imem[7]  = enc(3, 3, 2, 0);
        imem[8]  = enc(4, 7, 3, 0);
        imem[9]  = enc(0, 3, 1, 0);
        imem[10] = enc(2, 3, 0, 256 | b);
        imem[11] = enc(4, 7, 3, 0);
        imem[12] = enc(3, 3, 0, 256 | b);
        imem[13] = enc(4, 7, 3, 0);
        imem[14] = enc(1, 0, 0, a);
        imem[15] = enc(4, 7, 0, 0);
        imem[16] = 16'h0000;
        imem[17] = enc(6 + (ai % 10), 1, 0, 8'h11);
        imem[18] = enc(4, 7, 1, 0);
        imem[19] = enc(5, 0, 0, 0);
        imem[20] = enc(1, 6, 0, 1);
        imem[21] = enc(4, 7, 6, 0);
        imem[22] = enc(5, 6, 0, 22);
        startRun();
        repeat (30) @(negedge clk);
        check("R6 store count", logCnt, 7);
        for (int i = 0; i < 7; i++) check("R6 store addr", logAddr[i], a);
        check("R3 add reg", logData[0], (a + b) & 255);
        check("R3 sub reg", logData[1], (a - b) & 255);
        check("R4 add imm", logData[2], (a + b) & 255);
        check("R4 sub imm", logData[3], a);
        check("R5 zero reg", logData[4], 0);
        check("R9 R2 unused op and nop", logData[5], a);
        check("R7 untaken jump R1", logData[6], 1);
        check("R7 final pc", imemAddr, 22);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule